// File: doc/BRIEF.md
# Vector Prefix Instruction Detector

This block sits between instruction fetch and the instruction decoder. It looks at every fetched word and decides whether that word is a vector-extension prefix or an ordinary instruction. An ordinary instruction is passed straight on. A prefix is not passed on by itself. Instead, the block captures the 24-bit remap field that the prefix carries and waits for the next word, which is the real (suffix) instruction. It then presents the suffix to the decoder together with the captured remap field and a flag that marks the pair as prefixed.

The output is a single registered slot with a valid/ready handshake. Along with the instruction, the slot carries the program counter of the instruction or pair, the amount the program counter advances by (4 for a single word, 8 for a pair), and the remap field split into its subfields. A flush empties the slot and drops any prefix that is still waiting for its suffix.

Bit positions below are given in LSB0 numbering of the 32-bit instruction word. In the word's MSB0 numbering, MSB0 bit k is LSB0 bit 31-k.

Top module: `vpfx_detect`

## Requirements
- R1: A word is a prefix exactly when its bits [31:26] equal 6'b000001 and bits 24 and 22 are both 1. Every other word is a plain instruction.
- R2: A plain word accepted in the first-word state appears at the output on the next cycle. The output carries that word's low 32 bits, a remap of zero, prefixed flag 0, the word's PC and a PC increment of 4.
- R3: The remap field of a prefix is formed as follows: remap[23] = word[25], remap[22] = word[23], and remap[21:0] = word[21:0].
- R4: An accepted prefix produces no output. The next accepted word is output as the suffix on the cycle after it is accepted. The output then carries prefixed flag 1, the prefix's remap field, the prefix's PC and a PC increment of 8.
- R5: A word accepted while a suffix is awaited is taken as the suffix even if it has the form of a prefix.
- R6: The remap subfields are driven from the output remap as follows: mask mode = remap[23], mask = remap[22:20], element width = remap[19:18], source element width = remap[17:16], subvector length = remap[15:14], extra = remap[13:5], mode = remap[4:0].
- R7: While a suffix is awaited, the output stays invalid for any number of idle cycles, and the captured prefix is kept.
- R8: While the output is valid and not taken, its contents stay unchanged and fetch_ready is low. Otherwise fetch_ready is high unless flush is asserted.
- R9: A flush makes the output invalid on the next cycle and discards a pending prefix, so the next word is classified as a first word. fetch_ready is low while flush is high.
- R10: After reset the output is invalid and the block expects a first word.
- R11: Fetch word bits above bit 31 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discards the output slot and any pending prefix |
| fetch_valid | input | 1 | A fetch word is offered |
| fetch_ready | output | 1 | The block accepts the offered word |
| fetch_word | input | FETCH_W (64) | Fetched value; only the low 32 bits are used |
| fetch_pc | input | PC_W (64) | PC of the offered word |
| dec_valid | output | 1 | Output slot holds an instruction |
| dec_ready | input | 1 | Decoder takes the slot |
| dec_insn | output | 32 | Instruction (the suffix for a pair) |
| dec_remap | output | 24 | Remap field (zero for a plain instruction) |
| dec_prefixed | output | 1 | The slot holds a prefixed pair |
| dec_pc | output | PC_W (64) | PC of the instruction or of the pair's prefix |
| dec_pc_inc | output | 4 | PC advance: 4 or 8 |
| rm_mask_mode | output | 1 | Remap mask-mode subfield |
| rm_mask | output | 3 | Remap mask subfield |
| rm_elwidth | output | 2 | Remap element-width subfield |
| rm_src_elwidth | output | 2 | Remap source element-width subfield |
| rm_subvl | output | 2 | Remap subvector-length subfield |
| rm_extra | output | 9 | Remap extra subfield |
| rm_mode | output | 5 | Remap mode subfield |

## Verification
The bench targets the following corner cases:
- Near-miss words that have the major opcode but only one of the two identifying bits. A detector that checked only the opcode would swallow these as prefixes and lose an instruction.
- A suffix that itself looks like a prefix. A design that re-classifies the suffix would hang waiting for a third word.
- Prefixes followed by idle gaps, backpressure and flushes. A wrong hold or flush path would emit a pair with a stale remap or PC, or would pair a word after the flush with a discarded prefix.
- All-ones and all-zero remap fields with random upper fetch bits. These expose a field gathered from the wrong positions or leaking bits above bit 31.

// File: rtl/vpfx_pkg.sv
`timescale 1ns/1ps
package vpfx_pkg;

  localparam int INSN_W = 32;
  localparam int RM_W   = 24;
  localparam logic [5:0] PFX_MAJOR = 6'd1;
  localparam logic [3:0] STEP_ONE  = 4'd4;
  localparam logic [3:0] STEP_PAIR = 4'd8;

  typedef enum logic {EXPECT_FIRST, EXPECT_SUFFIX} seq_state_t;

  // Remap subfields, most significant first (mask mode sits at remap[23]).
  typedef struct packed {
    logic       mmode;
    logic [2:0] mask;
    logic [1:0] elw;
    logic [1:0] srcelw;
    logic [1:0] subvl;
    logic [8:0] extra;
    logic [4:0] mode;
  } rm_fields_t;

  // Prefix test: major opcode in the top six bits, identifiers at 24 and 22.
  function automatic logic is_prefix(input logic [INSN_W-1:0] w);
    return (w[31:26] == PFX_MAJOR) && w[24] && w[22];
  endfunction

  // Remap gather: bit 25, then bit 23, then the low 22 bits.
  function automatic logic [RM_W-1:0] gather_rm(input logic [INSN_W-1:0] w);
    return {w[25], w[23], w[21:0]};
  endfunction

  function automatic rm_fields_t split_rm(input logic [RM_W-1:0] rm);
    rm_fields_t f;
    f.mmode  = rm[23];
    f.mask   = rm[22:20];
    f.elw    = rm[19:18];
    f.srcelw = rm[17:16];
    f.subvl  = rm[15:14];
    f.extra  = rm[13:5];
    f.mode   = rm[4:0];
    return f;
  endfunction

  function automatic logic [3:0] pc_step(input logic paired);
    return paired ? STEP_PAIR : STEP_ONE;
  endfunction

endpackage

// File: rtl/vpfx_classify.sv
`timescale 1ns/1ps
module vpfx_classify
  import vpfx_pkg::*;
#(
  parameter int FETCH_W = 64
) (
  input  logic [FETCH_W-1:0] fetch_word,
  output logic [INSN_W-1:0]  insn,
  output logic               is_pfx,
  output logic [RM_W-1:0]    word_rm
);

  assign insn    = fetch_word[INSN_W-1:0];
  assign is_pfx  = is_prefix(insn);
  assign word_rm = gather_rm(insn);

  // Upper fetch bits carry nothing for this block.
  generate
    if (FETCH_W > INSN_W) begin : g_wide
      logic unused_hi;
      assign unused_hi = ^fetch_word[FETCH_W-1:INSN_W];
    end
  endgenerate

endmodule

// File: rtl/vpfx_seq.sv
`timescale 1ns/1ps
module vpfx_seq
  import vpfx_pkg::*;
#(
  parameter int PC_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              take,
  input  logic              is_pfx,
  input  logic [INSN_W-1:0] insn,
  input  logic [RM_W-1:0]   word_rm,
  input  logic [PC_W-1:0]   word_pc,
  output logic              state_suffix,
  output logic              accept_prefix,
  output logic              load,
  output logic [INSN_W-1:0] load_insn,
  output logic [RM_W-1:0]   load_rm,
  output logic              load_pref,
  output logic [PC_W-1:0]   load_pc
);

  seq_state_t          state_q, state_d;
  logic [RM_W-1:0]     held_rm;
  logic [PC_W-1:0]     held_pc;
  logic                load_plain;
  logic                load_pair;

  assign state_suffix  = (state_q == EXPECT_SUFFIX);
  assign accept_prefix = take && !state_suffix && is_pfx;
  assign load_plain    = take && !state_suffix && !is_pfx;
  assign load_pair     = take && state_suffix;

  always_comb begin
    state_d = state_q;
    if (flush)              state_d = EXPECT_FIRST;
    else if (accept_prefix) state_d = EXPECT_SUFFIX;
    else if (load_pair)     state_d = EXPECT_FIRST;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= EXPECT_FIRST;
      held_rm <= '0;
      held_pc <= '0;
    end else begin
      state_q <= state_d;
      if (accept_prefix) begin
        held_rm <= word_rm;
        held_pc <= word_pc;
      end
    end
  end

  assign load      = load_plain || load_pair;
  assign load_insn = insn;
  assign load_pref = load_pair;
  assign load_rm   = load_pair ? held_rm : '0;
  assign load_pc   = load_pair ? held_pc : word_pc;

endmodule

// File: rtl/vpfx_outreg.sv
`timescale 1ns/1ps
module vpfx_outreg
  import vpfx_pkg::*;
#(
  parameter int PC_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              load,
  input  logic [INSN_W-1:0] load_insn,
  input  logic [RM_W-1:0]   load_rm,
  input  logic              load_pref,
  input  logic [PC_W-1:0]   load_pc,
  input  logic              dec_ready,
  output logic              slot_free,
  output logic              dec_valid,
  output logic [INSN_W-1:0] dec_insn,
  output logic [RM_W-1:0]   dec_remap,
  output logic              dec_prefixed,
  output logic [PC_W-1:0]   dec_pc,
  output logic [3:0]        dec_pc_inc
);

  assign slot_free = !dec_valid || dec_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid    <= 1'b0;
      dec_insn     <= '0;
      dec_remap    <= '0;
      dec_prefixed <= 1'b0;
      dec_pc       <= '0;
    end else begin
      if (flush)          dec_valid <= 1'b0;
      else if (load)      dec_valid <= 1'b1;
      else if (dec_ready) dec_valid <= 1'b0;
      if (load && !flush) begin
        dec_insn     <= load_insn;
        dec_remap    <= load_rm;
        dec_prefixed <= load_pref;
        dec_pc       <= load_pc;
      end
    end
  end

  assign dec_pc_inc = pc_step(dec_prefixed);

endmodule

// File: rtl/vpfx_field_split.sv
`timescale 1ns/1ps
module vpfx_field_split
  import vpfx_pkg::*;
(
  input  logic [RM_W-1:0] remap,
  output logic            mmode,
  output logic [2:0]      mask,
  output logic [1:0]      elw,
  output logic [1:0]      srcelw,
  output logic [1:0]      subvl,
  output logic [8:0]      extra,
  output logic [4:0]      mode
);

  rm_fields_t f;
  assign f      = split_rm(remap);
  assign mmode  = f.mmode;
  assign mask   = f.mask;
  assign elw    = f.elw;
  assign srcelw = f.srcelw;
  assign subvl  = f.subvl;
  assign extra  = f.extra;
  assign mode   = f.mode;

endmodule

// File: rtl/vpfx_detect.sv
`timescale 1ns/1ps
module vpfx_detect
  import vpfx_pkg::*;
#(
  parameter int FETCH_W = 64,
  parameter int PC_W    = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               fetch_valid,
  output logic               fetch_ready,
  input  logic [FETCH_W-1:0] fetch_word,
  input  logic [PC_W-1:0]    fetch_pc,
  output logic               dec_valid,
  input  logic               dec_ready,
  output logic [31:0]        dec_insn,
  output logic [23:0]        dec_remap,
  output logic               dec_prefixed,
  output logic [PC_W-1:0]    dec_pc,
  output logic [3:0]         dec_pc_inc,
  output logic               rm_mask_mode,
  output logic [2:0]         rm_mask,
  output logic [1:0]         rm_elwidth,
  output logic [1:0]         rm_src_elwidth,
  output logic [1:0]         rm_subvl,
  output logic [8:0]         rm_extra,
  output logic [4:0]         rm_mode
);

  // Named internal events, visible to the bound checker.
  logic              take;
  logic              accept_prefix;
  logic              state_suffix;
  logic              slot_free;
  logic              is_pfx;
  logic [INSN_W-1:0] insn;
  logic [RM_W-1:0]   word_rm;
  logic              load;
  logic [INSN_W-1:0] load_insn;
  logic [RM_W-1:0]   load_rm;
  logic              load_pref;
  logic [PC_W-1:0]   load_pc;

  assign fetch_ready = !flush && slot_free;
  assign take        = fetch_valid && fetch_ready;

  vpfx_classify #(.FETCH_W(FETCH_W)) u_classify (
    .fetch_word (fetch_word),
    .insn       (insn),
    .is_pfx     (is_pfx),
    .word_rm    (word_rm)
  );

  vpfx_seq #(.PC_W(PC_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush         (flush),
    .take          (take),
    .is_pfx        (is_pfx),
    .insn          (insn),
    .word_rm       (word_rm),
    .word_pc       (fetch_pc),
    .state_suffix  (state_suffix),
    .accept_prefix (accept_prefix),
    .load          (load),
    .load_insn     (load_insn),
    .load_rm       (load_rm),
    .load_pref     (load_pref),
    .load_pc       (load_pc)
  );

  vpfx_outreg #(.PC_W(PC_W)) u_outreg (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .load         (load),
    .load_insn    (load_insn),
    .load_rm      (load_rm),
    .load_pref    (load_pref),
    .load_pc      (load_pc),
    .dec_ready    (dec_ready),
    .slot_free    (slot_free),
    .dec_valid    (dec_valid),
    .dec_insn     (dec_insn),
    .dec_remap    (dec_remap),
    .dec_prefixed (dec_prefixed),
    .dec_pc       (dec_pc),
    .dec_pc_inc   (dec_pc_inc)
  );

  vpfx_field_split u_split (
    .remap  (dec_remap),
    .mmode  (rm_mask_mode),
    .mask   (rm_mask),
    .elw    (rm_elwidth),
    .srcelw (rm_src_elwidth),
    .subvl  (rm_subvl),
    .extra  (rm_extra),
    .mode   (rm_mode)
  );

endmodule

// File: rtl/vpfx_detect_chk.sv
`timescale 1ns/1ps
module vpfx_detect_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        flush,
  input logic        fetch_ready,
  input logic        dec_valid,
  input logic        dec_ready,
  input logic [31:0] dec_insn,
  input logic [23:0] dec_remap,
  input logic        dec_prefixed,
  input logic [3:0]  dec_pc_inc,
  input logic        take,
  input logic        accept_prefix,
  input logic        state_suffix
);

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready && !flush) |=> (dec_valid && $stable(dec_insn) && $stable(dec_remap)));

  // R8
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |-> !fetch_ready);

  // R2
  plain_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_prefixed) |-> (dec_remap == 24'd0 && dec_pc_inc == 4'd4));

  // R4
  pair_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_prefixed) |-> (dec_pc_inc == 4'd8));

  // R7
  prefix_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_prefix && !flush) |=> (!dec_valid && state_suffix));

  // R4
  suffix_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && state_suffix) |=> (dec_valid && dec_prefixed));

  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!dec_valid && !state_suffix));

endmodule

bind vpfx_detect vpfx_detect_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .flush         (flush),
  .fetch_ready   (fetch_ready),
  .dec_valid     (dec_valid),
  .dec_ready     (dec_ready),
  .dec_insn      (dec_insn),
  .dec_remap     (dec_remap),
  .dec_prefixed  (dec_prefixed),
  .dec_pc_inc    (dec_pc_inc),
  .take          (take),
  .accept_prefix (accept_prefix),
  .state_suffix  (state_suffix)
);

// File: tb/vpfx_detect_tb_top.sv
`timescale 1ns/1ps
module vpfx_detect_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        fetch_valid = 1'b0;
  logic        fetch_ready;
  logic [63:0] fetch_word = '0;
  logic [63:0] fetch_pc = '0;
  logic        dec_valid;
  logic        dec_ready = 1'b0;
  logic [31:0] dec_insn;
  logic [23:0] dec_remap;
  logic        dec_prefixed;
  logic [63:0] dec_pc;
  logic [3:0]  dec_pc_inc;
  logic        rm_mask_mode;
  logic [2:0]  rm_mask;
  logic [1:0]  rm_elwidth, rm_src_elwidth, rm_subvl;
  logic [8:0]  rm_extra;
  logic [4:0]  rm_mode;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  vpfx_detect dut_i (.*);

  // Bench model state
  bit          m_pend = 0;
  logic [23:0] m_prm = '0;
  logic [63:0] m_ppc = '0;
  bit          m_ov = 0;
  logic [31:0] m_insn = '0;
  logic [23:0] m_rm = '0;
  bit          m_pref = 0;
  logic [63:0] m_pc = '0;

  function automatic bit mbit(input logic [31:0] w, input int k);
    return w[31-k];
  endfunction

  function automatic bit b_is_pfx(input logic [31:0] w);
    int op = 0;
    for (int k = 0; k < 6; k++) op = (op << 1) | int'(mbit(w, k));
    return (op == 1) && mbit(w, 7) && mbit(w, 9);
  endfunction

  function automatic logic [23:0] b_gather(input logic [31:0] w);
    logic [23:0] r = '0;
    for (int i = 0; i < 24; i++) begin
      int src = (i == 0) ? 6 : (i == 1) ? 8 : i + 8;
      r[23-i] = mbit(w, src);
    end
    return r;
  endfunction

  function automatic logic [63:0] b_fld(input logic [23:0] rm, input int start, input int len);
    logic [63:0] v = '0;
    for (int k = 0; k < len; k++) v = (v << 1) | 64'(rm[23-(start+k)]);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [63:0] w, input logic [63:0] pc,
                      input bit ordy, input bit fl);
    bit rdy;
    logic [31:0] lw;
    @(negedge clk);
    fetch_valid = v; fetch_word = w; fetch_pc = pc; dec_ready = ordy; flush = fl;
    #1;
    chk(dec_valid == m_ov, "R7", "dec_valid", 64'(dec_valid), 64'(m_ov));
    if (m_ov) begin
      chk(dec_insn == m_insn, "R2", "dec_insn", 64'(dec_insn), 64'(m_insn));
      chk(dec_remap == m_rm, "R3", "dec_remap", 64'(dec_remap), 64'(m_rm));
      chk(dec_prefixed == m_pref, "R4", "dec_prefixed", 64'(dec_prefixed), 64'(m_pref));
      chk(dec_pc == m_pc, "R4", "dec_pc", dec_pc, m_pc);
      chk(dec_pc_inc == (m_pref ? 4'd8 : 4'd4), "R4", "dec_pc_inc",
          64'(dec_pc_inc), m_pref ? 64'd8 : 64'd4);
      chk({rm_mask_mode, rm_mask, rm_elwidth, rm_src_elwidth, rm_subvl, rm_extra, rm_mode} ==
          {b_fld(m_rm,0,1) == 1, 3'(b_fld(m_rm,1,3)), 2'(b_fld(m_rm,4,2)), 2'(b_fld(m_rm,6,2)),
           2'(b_fld(m_rm,8,2)), 9'(b_fld(m_rm,10,9)), 5'(b_fld(m_rm,19,5))},
          "R6", "subfields", 64'({rm_mask_mode, rm_mask, rm_elwidth, rm_src_elwidth,
          rm_subvl, rm_extra, rm_mode}), 64'(m_rm));
    end
    rdy = !fl && (!m_ov || ordy);
    chk(fetch_ready == rdy, fl ? "R9" : "R8", "fetch_ready", 64'(fetch_ready), 64'(rdy));
    // advance model across the coming edge
    if (fl) begin
      m_ov = 0; m_pend = 0;
    end else begin
      if (m_ov && ordy) m_ov = 0;
      if (v && rdy) begin
        lw = w[31:0];
        if (m_pend) begin
          m_ov = 1; m_insn = lw; m_rm = m_prm; m_pref = 1; m_pc = m_ppc; m_pend = 0;
        end else if (b_is_pfx(lw)) begin
          m_pend = 1; m_prm = b_gather(lw); m_ppc = pc;
        end else begin
          m_ov = 1; m_insn = lw; m_rm = '0; m_pref = 0; m_pc = pc;
        end
      end
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [63:0] pc;
    logic [63:0] w;
    void'($urandom(32'h5eed));
    // R10: outputs during and after reset
    repeat (3) begin
      @(negedge clk);
      chk(dec_valid == 0, "R10", "dec_valid in reset", 64'(dec_valid), 0);
    end
    @(negedge clk); rst_n = 1'b1;
    #1 chk(fetch_ready == 1 && dec_valid == 0, "R10", "idle after reset",
           64'({fetch_ready, dec_valid}), 64'b10);

    // R2 plain word, R11 upper bits set
    step(1, 64'hFFFF_FFFF_7C08_02A6, 64'h100, 1, 0);
    // R1 near misses: one identifier missing, or wrong opcode
    step(1, 64'h0000_0000_0500_0000, 64'h104, 1, 0);
    step(1, 64'h0000_0000_0440_0000, 64'h108, 1, 0);
    step(1, 64'h0000_0000_0940_0000, 64'h10C, 1, 0);
    // R3/R7 all-ones remap prefix, idle gap, then suffix
    step(1, 64'h1234_5678_07FF_FFFF, 64'h200, 1, 0);
    step(0, 64'h0, 64'h0, 1, 0);
    step(0, 64'h0, 64'h0, 0, 0);
    step(0, 64'h0, 64'h0, 1, 0);
    step(1, 64'h0000_0000_3860_0001, 64'h204, 1, 0);
    // R5 suffix that looks like a prefix
    step(1, 64'h0000_0000_0540_0000, 64'h300, 1, 0);
    step(1, 64'h0000_0000_07FF_FFFF, 64'h304, 1, 0);
    step(1, 64'h0000_0000_6000_0000, 64'h308, 1, 0);
    // R9 flush drops a pending prefix
    step(1, 64'h0000_0000_05C0_1234, 64'h400, 1, 0);
    step(1, 64'h0000_0000_7C00_0000, 64'h404, 1, 1);
    step(1, 64'h0000_0000_7C00_0001, 64'h500, 1, 0);
    // R8 backpressure with a pending output
    step(1, 64'h0000_0000_3800_0005, 64'h600, 0, 0);
    step(1, 64'h0000_0000_3800_0006, 64'h604, 0, 0);
    step(1, 64'h0000_0000_3800_0007, 64'h608, 0, 0);
    step(1, 64'h0000_0000_3800_0008, 64'h60C, 1, 0);
    step(0, 64'h0, 64'h0, 1, 0);

    // Constrained random traffic
    pc = 64'h1000;
    for (int n = 0; n < 3000; n++) begin
      int sel = int'($urandom % 100);
      w = {$urandom, $urandom};
      if (sel < 40) begin
        w[31:26] = 6'd1; w[24] = 1'b1; w[22] = 1'b1;
      end else if (sel < 50) begin
        w[31:26] = 6'd1; w[24] = 1'b1; w[22] = 1'b0;
        if ($urandom % 2 == 0) begin w[24] = 1'b0; w[22] = 1'b1; end
      end
      step(($urandom % 4) != 0, w, pc, ($urandom % 3) != 0, ($urandom % 40) == 0);
      pc = pc + 64'd4;
    end
    step(0, 64'h0, 64'h0, 1, 0);
    step(0, 64'h0, 64'h0, 1, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule